// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Port

This block connects a processor's simple synchronous register port to a character source and a character sink. Incoming characters arrive on a byte input with a one-cycle valid strobe. The block holds the most recent one and flags it as waiting until software reads it. Outgoing characters are written by software into a holding register. They are offered to a downstream consumer on a byte output, and the consumer can hold them off with a busy signal. Each direction has its own ready flag and its own interrupt-enable flag. Each drives its own interrupt level.

Software sees four 32-bit registers, chosen by address bits 3..2. The receive status register is at 0x0, the received character at 0x4, the send status register at 0x8 and the character to send at 0xC. In both status registers, bit 0 is a hardware-owned ready flag and bit 1 is a software-owned interrupt enable. All other bits read as zero. Read data is a combinational function of the address. Only a read of the received character with the read strobe high has a side effect.

Top module: `mmio_char_port`

## Requirements
- R1: After reset, the receive status register (0x0) reads 0 and the send status register (0x8) reads 1, meaning ready with the interrupt disabled. `irq` is 0 and `tx_valid` is 0.
- R2: A cycle with `rx_valid` high stores `rx_byte` and sets receive ready. Both are visible one cycle later: bit 0 of 0x0 reads 1, and 0x4 returns the byte in bits 7..0 with zeros above.
- R3: A clock edge with `bus_rd` high and address 0x4 clears receive ready. If `rx_valid` is high on the same edge, the new byte is stored and ready stays 1.
- R4: A byte that arrives while receive ready is already 1 replaces the held byte, and ready stays 1.
- R5: Bit 1 of 0x0 is readable and writable and resets to 0. `irq[1]` is high exactly while that bit and receive ready are both 1.
- R6: A write to 0xC while send ready is 1 loads `bus_wdata[7:0]` and clears send ready. From the next cycle, `tx_valid` is 1 and `tx_byte` carries the loaded byte.
- R7: `tx_valid` and `tx_byte` stay unchanged while `tx_busy` is 1. On the first edge where `tx_valid` is 1 and `tx_busy` is 0, the byte is taken. After that edge, `tx_valid` is 0 and send ready is 1.
- R8: A write to 0xC while send ready is 0 has no effect: the byte on `tx_byte` and in 0xC is unchanged.
- R9: Bit 1 of 0x8 is readable and writable and resets to 0. `irq[0]` is high exactly while that bit and send ready are both 1.
- R10: Writes to bit 0 of either status register and writes to 0x4 are ignored. Address bits 1..0 do not affect the register selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte address; bits 3..2 select the register |
| bus_rd | input | 1 | Read strobe; gives the read of 0x4 its side effect |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_byte | input | 8 | Incoming character |
| rx_valid | input | 1 | Incoming character strobe |
| tx_byte | output | 8 | Outgoing character |
| tx_valid | output | 1 | Outgoing character is pending |
| tx_busy | input | 1 | Consumer cannot take the character this cycle |
| irq | output | 2 | Interrupt levels: bit 1 receive, bit 0 send |

## Verification
The bench targets four corner cases.

- An arrival on the same edge as a clearing read. A design that lets the read win loses the new character's ready flag.
- A back-to-back arrival while ready is set. A design that drops the second byte keeps stale data.
- A write to the send register while the consumer is stalled. A design that accepts it corrupts a byte already on `tx_byte`.
- The release of `tx_busy`. A design that mistimes it either reports ready early or never raises `tx_valid` low.

Writes aimed at the ready bits and at the receive data register are checked by reading back. A model-driven random phase mixes all of these with interrupt enables toggling.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
   // register select taken from address bits 3..2
   typedef enum logic [1:0] {
      SEL_RX_STAT = 2'd0,
      SEL_RX_CHAR = 2'd1,
      SEL_TX_STAT = 2'd2,
      SEL_TX_CHAR = 2'd3
   } mcp_sel_e;

   localparam int unsigned STAT_RDY_BIT = 0;
   localparam int unsigned STAT_IE_BIT  = 1;
   localparam int unsigned SEL_LSB      = 2;
endpackage

// File: rtl/mcp_bus_dec.sv
module mcp_bus_dec
   import mcp_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CHAR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              we,
   input  logic              rx_rdy,
   input  logic              rx_ie,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              tx_rdy,
   input  logic              tx_ie,
   input  logic [CHAR_W-1:0] tx_char,
   output logic              wr_rx_stat,
   output logic              rd_rx_char,
   output logic              wr_tx_stat,
   output logic              wr_tx_char,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned CHAR_PAD = DATA_W - CHAR_W;
   localparam int unsigned STAT_PAD = DATA_W - 2;

   mcp_sel_e sel;
   assign sel = mcp_sel_e'(addr[SEL_LSB +: 2]);

   assign wr_rx_stat = we && (sel == SEL_RX_STAT);
   assign rd_rx_char = rd && (sel == SEL_RX_CHAR);
   assign wr_tx_stat = we && (sel == SEL_TX_STAT);
   assign wr_tx_char = we && (sel == SEL_TX_CHAR);

   always_comb begin
      unique case (sel)
         SEL_RX_STAT: rdata = {{STAT_PAD{1'b0}}, rx_ie, rx_rdy};
         SEL_RX_CHAR: rdata = {{CHAR_PAD{1'b0}}, rx_char};
         SEL_TX_STAT: rdata = {{STAT_PAD{1'b0}}, tx_ie, tx_rdy};
         default:     rdata = {{CHAR_PAD{1'b0}}, tx_char};
      endcase
   end
endmodule

// File: rtl/mcp_rx_chan.sv
module mcp_rx_chan #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] in_byte,
   input  logic              in_valid,
   input  logic              rd_char,
   input  logic              wr_stat,
   input  logic              ie_wval,
   output logic              rdy,
   output logic              ie,
   output logic [CHAR_W-1:0] held,
   output logic              irq_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy  <= 1'b0;
         ie   <= 1'b0;
         held <= '0;
      end else begin
         // an arrival wins over a clearing read on the same edge
         if (in_valid) begin
            held <= in_byte;
            rdy  <= 1'b1;
         end else if (rd_char) begin
            rdy  <= 1'b0;
         end
         if (wr_stat) ie <= ie_wval;
      end
   end

   assign irq_req = ie & rdy;

   AST_RX_ARRIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (rdy && held == $past(in_byte)));                    // R2
   AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_char && !in_valid) |=> !rdy);                                 // R3
   AST_RX_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(held));                                     // R4
endmodule

// File: rtl/mcp_tx_chan.sv
module mcp_tx_chan #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_char,
   input  logic [CHAR_W-1:0] char_wval,
   input  logic              wr_stat,
   input  logic              ie_wval,
   input  logic              out_busy,
   output logic              rdy,
   output logic              ie,
   output logic [CHAR_W-1:0] held,
   output logic              out_valid,
   output logic              irq_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy  <= 1'b1;
         ie   <= 1'b0;
         held <= '0;
      end else begin
         if (!rdy && !out_busy) begin
            rdy  <= 1'b1;
         end else if (wr_char && rdy) begin
            held <= char_wval;
            rdy  <= 1'b0;
         end
         if (wr_stat) ie <= ie_wval;
      end
   end

   assign out_valid = ~rdy;
   assign irq_req   = ie & rdy;

   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_char && rdy) |=> (!rdy && held == $past(char_wval)));         // R6
   AST_TX_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && out_busy) |=> (!rdy && $stable(held)));                  // R7
   AST_TX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && !out_busy) |=> rdy);                                     // R7
   AST_TX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_char && !rdy) |=> $stable(held));                             // R8
endmodule

// File: rtl/mcp_irq_map.sv
module mcp_irq_map #(
   parameter int unsigned NUM_LVL = 2,
   parameter int unsigned RX_LVL  = 1,
   parameter int unsigned TX_LVL  = 0
) (
   input  logic               rx_req,
   input  logic               tx_req,
   output logic [NUM_LVL-1:0] lvl
);
   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      if (l == RX_LVL && l == TX_LVL) begin : g_both
         assign lvl[l] = rx_req | tx_req;
      end else if (l == RX_LVL) begin : g_rx
         assign lvl[l] = rx_req;
      end else if (l == TX_LVL) begin : g_tx
         assign lvl[l] = tx_req;
      end else begin : g_none
         assign lvl[l] = 1'b0;
      end
   end
endmodule

// File: rtl/mmio_char_port.sv
module mmio_char_port
   import mcp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned NUM_LVL = 2,
   parameter int unsigned RX_LVL  = 1,
   parameter int unsigned TX_LVL  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [CHAR_W-1:0]  rx_byte,
   input  logic               rx_valid,
   output logic [CHAR_W-1:0]  tx_byte,
   output logic               tx_valid,
   input  logic               tx_busy,
   output logic [NUM_LVL-1:0] irq
);
   if (ADDR_W < SEL_LSB + 2) begin : g_chk_addr
      $error("mmio_char_port: ADDR_W must cover the register select bits");
   end
   if (CHAR_W < 1 || CHAR_W >= DATA_W || DATA_W < 3) begin : g_chk_char
      $error("mmio_char_port: CHAR_W must be nonzero and narrower than DATA_W");
   end
   if (RX_LVL >= NUM_LVL || TX_LVL >= NUM_LVL) begin : g_chk_lvl
      $error("mmio_char_port: interrupt level out of range");
   end

   logic              wr_rx_stat, rd_rx_char, wr_tx_stat, wr_tx_char;
   logic              rx_rdy, rx_ie, rx_req;
   logic              tx_rdy, tx_ie, tx_req;
   logic [CHAR_W-1:0] rx_held, tx_held;
   logic              unused_bus_bits;

   assign unused_bus_bits = ^{bus_addr, bus_wdata};

   mcp_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dec (
      .addr       (bus_addr),
      .rd         (bus_rd),
      .we         (bus_we),
      .rx_rdy     (rx_rdy),
      .rx_ie      (rx_ie),
      .rx_char    (rx_held),
      .tx_rdy     (tx_rdy),
      .tx_ie      (tx_ie),
      .tx_char    (tx_held),
      .wr_rx_stat (wr_rx_stat),
      .rd_rx_char (rd_rx_char),
      .wr_tx_stat (wr_tx_stat),
      .wr_tx_char (wr_tx_char),
      .rdata      (bus_rdata)
   );

   mcp_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_byte  (rx_byte),
      .in_valid (rx_valid),
      .rd_char  (rd_rx_char),
      .wr_stat  (wr_rx_stat),
      .ie_wval  (bus_wdata[STAT_IE_BIT]),
      .rdy      (rx_rdy),
      .ie       (rx_ie),
      .held     (rx_held),
      .irq_req  (rx_req)
   );

   mcp_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_char   (wr_tx_char),
      .char_wval (bus_wdata[CHAR_W-1:0]),
      .wr_stat   (wr_tx_stat),
      .ie_wval   (bus_wdata[STAT_IE_BIT]),
      .out_busy  (tx_busy),
      .rdy       (tx_rdy),
      .ie        (tx_ie),
      .held      (tx_held),
      .out_valid (tx_valid),
      .irq_req   (tx_req)
   );

   assign tx_byte = tx_held;

   mcp_irq_map #(.NUM_LVL(NUM_LVL), .RX_LVL(RX_LVL), .TX_LVL(TX_LVL)) u_irq (
      .rx_req (rx_req),
      .tx_req (tx_req),
      .lvl    (irq)
   );

   AST_RX_IRQ_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ie && !wr_rx_stat) |=> irq[RX_LVL]);              // R5
   AST_TX_CHAR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_busy) |=> (tx_valid && $stable(tx_byte)));        // R7
endmodule

// File: tb/mmio_char_port_tb.sv
`timescale 1ns/1ps
module mmio_char_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  tx_byte;
   logic        tx_valid;
   logic        tx_busy = 1'b0;
   logic [1:0]  irq;

   int total = 0, bad = 0;
   bit done = 0, model_on = 0;

   always #2 clk = ~clk;   // 250 MHz

   mmio_char_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_byte(tx_byte),
      .tx_valid(tx_valid), .tx_busy(tx_busy), .irq(irq)
   );

   // behavioural reference state
   bit       m_rx_rdy, m_rx_ie, m_tx_rdy, m_tx_ie;
   bit [7:0] m_rx_chr, m_tx_chr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rx_rdy = 0; m_rx_ie = 0; m_rx_chr = 0;
         m_tx_rdy = 1; m_tx_ie = 0; m_tx_chr = 0;
      end else begin
         int r;
         r = bus_addr[3:2];
         if (rx_valid) begin m_rx_chr = rx_byte; m_rx_rdy = 1; end
         else if (bus_rd && r == 1) m_rx_rdy = 0;
         if (bus_we && r == 0) m_rx_ie = bus_wdata[1];
         if (!m_tx_rdy && !tx_busy) m_tx_rdy = 1;
         else if (bus_we && r == 3 && m_tx_rdy) begin
            m_tx_chr = bus_wdata[7:0]; m_tx_rdy = 0;
         end
         if (bus_we && r == 2) m_tx_ie = bus_wdata[1];
      end
   end

   function automatic logic [31:0] m_read(input logic [3:0] a);
      case (a[3:2])
         2'd0: return {30'd0, m_rx_ie, m_rx_rdy};
         2'd1: return {24'd0, m_rx_chr};
         2'd2: return {30'd0, m_tx_ie, m_tx_rdy};
         default: return {24'd0, m_tx_chr};
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         check("R2 R10 model read data", bus_rdata, m_read(bus_addr));
         check("R5 R9 model irq", {30'd0, irq}, {30'd0, m_rx_ie & m_rx_rdy, m_tx_ie & m_tx_rdy});
         check("R6 R7 model tx_valid", {31'd0, tx_valid}, {31'd0, !m_tx_rdy});
         check("R6 R7 model tx_byte", {24'd0, tx_byte}, {24'd0, m_tx_chr});
      end
   end

   task automatic tick;
      @(posedge clk); #0.5;
   endtask

   task automatic peek(input logic [3:0] a, input string tag, input logic [31:0] exp);
      bus_addr = a; bus_rd = 0; #0.25;
      check(tag, bus_rdata, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1; tick; bus_we = 0;
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R7 watchdog expired: actual=running expected=finished");
         summary;
         $finish;
      end
   end

   initial begin
      repeat (3) tick;
      rst_n = 1;
      model_on = 1;
      // R1 reset values
      peek(4'h0, "R1 rx status", 32'h0);
      peek(4'h8, "R1 tx status", 32'h1);
      check("R1 irq", {30'd0, irq}, 32'h0);
      check("R1 tx_valid", {31'd0, tx_valid}, 32'h0);
      tick;
      // R2 arrival
      rx_byte = 8'h5A; rx_valid = 1; tick; rx_valid = 0;
      peek(4'h0, "R2 ready set", 32'h1);
      peek(4'h4, "R2 char zero-extended", 32'h5A);
      tick;
      // R4 overwrite while ready
      rx_byte = 8'hC3; rx_valid = 1; tick; rx_valid = 0;
      peek(4'h0, "R4 ready stays", 32'h1);
      peek(4'h4, "R4 char replaced", 32'hC3);
      tick;
      // R3 read clears
      bus_addr = 4'h4; bus_rd = 1; tick; bus_rd = 0;
      peek(4'h0, "R3 read clears ready", 32'h0);
      tick;
      // R3 arrival on same edge as read
      rx_byte = 8'h11; rx_valid = 1; bus_addr = 4'h4; bus_rd = 1; tick;
      rx_valid = 0; bus_rd = 0;
      peek(4'h0, "R3 arrival beats read", 32'h1);
      peek(4'h4, "R3 new char kept", 32'h11);
      bus_addr = 4'h4; bus_rd = 1; tick; bus_rd = 0;
      // R5 and R10: enable receive interrupt, attempt ready bit
      wr(4'h0, 32'h3);
      peek(4'h0, "R5 R10 ie set ready untouched", 32'h2);
      check("R5 no irq without char", {30'd0, irq}, 32'h0);
      rx_byte = 8'h77; rx_valid = 1; tick; rx_valid = 0;
      check("R5 irq on arrival", {30'd0, irq}, 32'h2);
      bus_addr = 4'h4; bus_rd = 1; tick; bus_rd = 0;
      check("R5 irq drops after read", {30'd0, irq}, 32'h0);
      wr(4'h0, 32'h0);
      // R10 receive data is not writable, low address bits ignored
      wr(4'h4, 32'hFF);
      peek(4'h4, "R10 rx char not written", 32'h77);
      peek(4'h0, "R10 rx ready not set by write", 32'h0);
      peek(4'h5, "R10 low address bits ignored", 32'h77);
      wr(4'h8, 32'h0);
      peek(4'h8, "R10 tx ready not cleared by write", 32'h1);
      // R9 send interrupt enable
      wr(4'h8, 32'h2);
      peek(4'h8, "R9 tx ie set", 32'h3);
      check("R9 irq while ready", {30'd0, irq}, 32'h1);
      // R6 load while consumer stalled
      tx_busy = 1;
      wr(4'hC, 32'h1A7);
      check("R6 tx_valid", {31'd0, tx_valid}, 32'h1);
      check("R6 tx_byte", {24'd0, tx_byte}, 32'hA7);
      peek(4'h8, "R6 tx ready cleared", 32'h2);
      check("R9 irq off while busy", {30'd0, irq}, 32'h0);
      // R8 write while not ready
      wr(4'hC, 32'h55);
      check("R8 tx_byte kept", {24'd0, tx_byte}, 32'hA7);
      peek(4'hC, "R8 tx char reg kept", 32'hA7);
      // R7 stall then release
      repeat (3) tick;
      check("R7 held during stall", {24'd0, tx_byte}, 32'hA7);
      check("R7 valid during stall", {31'd0, tx_valid}, 32'h1);
      tx_busy = 0; tick;
      check("R7 taken", {31'd0, tx_valid}, 32'h0);
      peek(4'h8, "R7 ready back", 32'h3);
      // R7 immediate acceptance
      wr(4'hC, 32'h42);
      check("R6 valid no stall", {31'd0, tx_valid}, 32'h1);
      check("R6 byte no stall", {24'd0, tx_byte}, 32'h42);
      tick;
      check("R7 taken next edge", {31'd0, tx_valid}, 32'h0);
      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         rx_valid  = ($urandom % 4) == 0;
         rx_byte   = 8'($urandom);
         bus_addr  = 4'($urandom);
         bus_rd    = ($urandom % 3) == 0;
         bus_we    = ($urandom % 4) == 0;
         bus_wdata = $urandom;
         tx_busy   = ($urandom % 3) != 0;
         tick;
      end
      rx_valid = 0; bus_rd = 0; bus_we = 0;
      tick;
      done = 1;
      summary;
      $finish;
   end
endmodule